// File: doc/BRIEF.md
# Nested transaction read/write-set tracker

This block keeps track of the lines that a stack of nested hardware transactions has read and written. Each tracked line carries one read bit and one write bit per nesting level, so every level owns its own read-set and write-set. A small command port opens closed or open child transactions, validates the innermost one, commits it and aborts any level together with the levels inside it. An access port records a read or a write by the innermost transaction. A snoop port takes remote writes and reports a conflict against any live set one cycle later.

Commit takes two steps. A validate command ends conflict checking for the innermost level, and any number of cycles may pass before the commit command. A closed child that commits folds its sets into its parent. An open child, or the outermost transaction, commits by publishing the lines it wrote and releasing its sets. The line store is a small fully associative tag array. A full array reports an overflow and does not change state.

Top module: `ntx_set_tracker`

## Requirements
- R1: After reset, depth is 0 and every output pulse (ready, err_commit, err_nest, ovf, viol_valid, pub_valid) is low, with viol_level 0 and pub_mask 0.
- R2: cmd_op 1 opens a closed child and cmd_op 2 opens an open child. Each raises depth by one after the clock edge. At depth LEVELS, either command leaves depth unchanged and pulses err_nest for one cycle.
- R3: With depth above 0, acc_valid records acc_addr in the innermost level's write-set when acc_write is 1 and in its read-set otherwise. A new address takes the lowest free line index. With depth 0 the access is ignored, so a later snoop of that address reports nothing.
- R4: A snoop (snp_valid) whose address matches a line holding any read or write bit raises viol_valid in the next cycle. viol_level then gives the shallowest matching level, counted from 1.
- R5: An access to a new address while every line is in use pulses ovf one cycle later and changes no state. A snoop of that address then reports nothing, and the lines already held still report.
- R6: cmd_op 3 (validate) pulses ready one cycle later only if no violation is pending for the innermost level. A snoop that hits that level in the same cycle counts as pending.
- R7: cmd_op 4 (commit) with no successful validate since the level opened, or with a violation on that level after its validate, pulses err_commit and leaves depth unchanged.
- R8: Committing a validated closed child at depth above 1 lowers depth by one and moves the child's read and write bits into the parent. The moved lines then report the parent's level, and nothing is published.
- R9: Committing a validated open child, or the outermost transaction, lowers depth by one. It pulses pub_valid with pub_mask bit i set for each line i in that level's write-set, and releases that level's bits.
- R10: cmd_op 5 (abort) with cmd_lvl N, where 1 <= N <= depth, clears the bits of level N and of every deeper level and sets depth to N-1. Any other N is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command: 0 none, 1 begin closed, 2 begin open, 3 validate, 4 commit, 5 abort |
| cmd_lvl | input | DEPTH_W | Level to abort, counted from 1 |
| acc_valid | input | 1 | Local access by the innermost transaction |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_addr | input | ADDR_W | Line address of the access |
| snp_valid | input | 1 | Remote write observed |
| snp_addr | input | ADDR_W | Line address of the remote write |
| depth | output | DEPTH_W | Current nesting depth |
| ready | output | 1 | Validate succeeded |
| err_commit | output | 1 | Commit rejected |
| err_nest | output | 1 | Begin rejected at full depth |
| ovf | output | 1 | No free line for a new address |
| viol_valid | output | 1 | Remote write conflicted with a live set |
| viol_level | output | DEPTH_W | Shallowest conflicting level |
| pub_valid | output | 1 | Write-set published |
| pub_mask | output | LINES | Lines published |

## Verification
The risky collision is a validate in the same cycle as a snoop that hits the innermost level. The bench drives both in one cycle and expects ready to stay low while viol_valid reports that level. The bench also places a hitting snoop between a successful validate and the commit, and expects the commit to be rejected. Every cycle, a scoreboard compares the whole output vector against an expectation that the driver queues for it.

// File: rtl/ntx_pkg.sv
package ntx_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_BEGIN_C  = 3'd1,
    OP_BEGIN_O  = 3'd2,
    OP_VALIDATE = 3'd3,
    OP_COMMIT   = 3'd4,
    OP_ABORT    = 3'd5
  } ntx_op_e;
endpackage

// File: rtl/ntx_tagstore.sv
module ntx_tagstore #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 16,
  parameter int LEVELS = 4,
  localparam int LVL_IW  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int LINE_IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LVL_IW-1:0] acc_lvl,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              clr_en,
  input  logic [LVL_IW-1:0] clr_from,
  input  logic              merge_en,
  input  logic [LVL_IW-1:0] merge_lvl,
  input  logic              rel_en,
  input  logic [LVL_IW-1:0] rel_lvl,
  output logic [LEVELS-1:0] snp_hit,
  output logic              ovf_o,
  output logic              pub_valid_o,
  output logic [LINES-1:0]  pub_mask_o
);
  logic [ADDR_W-1:0] tag_q [LINES];
  logic [ADDR_W-1:0] tag_n [LINES];
  logic [LEVELS-1:0] rd_q  [LINES];
  logic [LEVELS-1:0] rd_n  [LINES];
  logic [LEVELS-1:0] wr_q  [LINES];
  logic [LEVELS-1:0] wr_n  [LINES];
  logic [LINES-1:0]  live;
  logic              hit_any, free_any, ovf_n;
  logic [LINE_IW-1:0] hit_idx, free_idx, sel_idx;
  logic [LINES-1:0]  pub_n;
  logic [LVL_IW-1:0] parent;

  for (genvar g = 0; g < LINES; g++) begin : g_live
    assign live[g] = (|rd_q[g]) | (|wr_q[g]);
  end

  // associative lookup of the access address and lowest free line
  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (live[i] && tag_q[i] == acc_addr) begin
        hit_any = 1'b1;
        hit_idx = LINE_IW'(i);
      end
    end
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!live[i]) begin
        free_any = 1'b1;
        free_idx = LINE_IW'(i);
      end
    end
  end

  assign sel_idx = hit_any ? hit_idx : free_idx;

  // remote write compared against every line's per-level bits
  always_comb begin
    snp_hit = '0;
    for (int i = 0; i < LINES; i++) begin
      if (tag_q[i] == snp_addr) snp_hit = snp_hit | rd_q[i] | wr_q[i];
    end
  end

  assign parent = merge_lvl - 1'b1;

  always_comb begin
    tag_n = tag_q;
    rd_n  = rd_q;
    wr_n  = wr_q;
    ovf_n = 1'b0;
    if (acc_en) begin
      if (hit_any || free_any) begin
        tag_n[sel_idx] = acc_addr;
        if (acc_wr) wr_n[sel_idx][acc_lvl] = 1'b1;
        else        rd_n[sel_idx][acc_lvl] = 1'b1;
      end else begin
        ovf_n = 1'b1;
      end
    end
    for (int i = 0; i < LINES; i++) begin
      pub_n[i] = wr_n[i][rel_lvl];
    end
    for (int i = 0; i < LINES; i++) begin
      if (clr_en) begin
        for (int l = 0; l < LEVELS; l++) begin
          if (LVL_IW'(l) >= clr_from) begin
            rd_n[i][l] = 1'b0;
            wr_n[i][l] = 1'b0;
          end
        end
      end
      if (merge_en) begin
        rd_n[i][parent]    = rd_n[i][parent] | rd_n[i][merge_lvl];
        wr_n[i][parent]    = wr_n[i][parent] | wr_n[i][merge_lvl];
        rd_n[i][merge_lvl] = 1'b0;
        wr_n[i][merge_lvl] = 1'b0;
      end
      if (rel_en) begin
        rd_n[i][rel_lvl] = 1'b0;
        wr_n[i][rel_lvl] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    tag_q <= tag_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        rd_q[i] <= '0;
        wr_q[i] <= '0;
      end
      ovf_o       <= 1'b0;
      pub_valid_o <= 1'b0;
      pub_mask_o  <= '0;
    end else begin
      rd_q        <= rd_n;
      wr_q        <= wr_n;
      ovf_o       <= ovf_n;
      pub_valid_o <= rel_en;
      pub_mask_o  <= rel_en ? pub_n : '0;
    end
  end
endmodule

// File: rtl/ntx_viol.sv
module ntx_viol #(
  parameter int LEVELS = 4,
  localparam int DEPTH_W = $clog2(LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               snp_valid,
  input  logic [LEVELS-1:0]  snp_hit,
  output logic               viol_valid,
  output logic [DEPTH_W-1:0] viol_level
);
  logic [DEPTH_W-1:0] lvl_n;

  always_comb begin
    lvl_n = '0;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (snp_hit[l]) lvl_n = DEPTH_W'(l + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_valid <= 1'b0;
      viol_level <= '0;
    end else begin
      viol_valid <= snp_valid && (|snp_hit);
      viol_level <= snp_valid ? lvl_n : '0;
    end
  end
endmodule

// File: rtl/ntx_ctrl.sv
module ntx_ctrl
  import ntx_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int DEPTH_W = $clog2(LEVELS + 1),
  localparam int LVL_IW  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         cmd_op,
  input  logic [DEPTH_W-1:0] cmd_lvl,
  input  logic               acc_valid,
  input  logic               snp_valid,
  input  logic [LEVELS-1:0]  snp_hit,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               acc_en,
  output logic [LVL_IW-1:0]  acc_lvl,
  output logic               clr_en,
  output logic [LVL_IW-1:0]  clr_from,
  output logic               merge_en,
  output logic [LVL_IW-1:0]  merge_lvl,
  output logic               rel_en,
  output logic [LVL_IW-1:0]  rel_lvl,
  output logic               ready_o,
  output logic               err_commit_o,
  output logic               err_nest_o
);
  logic [DEPTH_W-1:0] depth_q, depth_n;
  logic [LEVELS-1:0]  open_q, open_n, ok_q, ok_n, pend_q, pend_n, hit_eff;
  logic               ready_n, cerr_n, nerr_n, has, full;
  logic [LVL_IW-1:0]  cur, par, nl;

  assign has     = depth_q != '0;
  assign full    = depth_q == DEPTH_W'(LEVELS);
  assign cur     = LVL_IW'(depth_q - 1'b1);
  assign par     = cur - 1'b1;
  assign nl      = LVL_IW'(depth_q);
  assign hit_eff = snp_valid ? snp_hit : '0;
  assign acc_en  = acc_valid && has;
  assign acc_lvl = cur;
  assign depth_o = depth_q;

  always_comb begin
    depth_n   = depth_q;
    open_n    = open_q;
    ok_n      = ok_q & ~hit_eff;
    pend_n    = pend_q | hit_eff;
    ready_n   = 1'b0;
    cerr_n    = 1'b0;
    nerr_n    = 1'b0;
    clr_en    = 1'b0;
    clr_from  = '0;
    merge_en  = 1'b0;
    merge_lvl = cur;
    rel_en    = 1'b0;
    rel_lvl   = cur;
    case (ntx_op_e'(cmd_op))
      OP_BEGIN_C, OP_BEGIN_O: begin
        if (full) begin
          nerr_n = 1'b1;
        end else begin
          open_n[nl] = (ntx_op_e'(cmd_op) == OP_BEGIN_O);
          ok_n[nl]   = 1'b0;
          pend_n[nl] = 1'b0;
          depth_n    = depth_q + 1'b1;
        end
      end
      OP_VALIDATE: begin
        if (has && !pend_n[cur]) begin
          ready_n  = 1'b1;
          ok_n[cur] = 1'b1;
        end
      end
      OP_COMMIT: begin
        if (!has || !ok_q[cur]) begin
          cerr_n = 1'b1;
        end else begin
          if (!open_q[cur] && depth_q > DEPTH_W'(1)) begin
            merge_en    = 1'b1;
            pend_n[par] = pend_n[par] | pend_n[cur];
          end else begin
            rel_en = 1'b1;
          end
          ok_n[cur]   = 1'b0;
          pend_n[cur] = 1'b0;
          open_n[cur] = 1'b0;
          depth_n     = depth_q - 1'b1;
        end
      end
      OP_ABORT: begin
        if (cmd_lvl != '0 && cmd_lvl <= depth_q) begin
          clr_en   = 1'b1;
          clr_from = LVL_IW'(cmd_lvl - 1'b1);
          depth_n  = cmd_lvl - 1'b1;
          for (int l = 0; l < LEVELS; l++) begin
            if (LVL_IW'(l) >= clr_from) begin
              ok_n[l]   = 1'b0;
              pend_n[l] = 1'b0;
              open_n[l] = 1'b0;
            end
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q      <= '0;
      open_q       <= '0;
      ok_q         <= '0;
      pend_q       <= '0;
      ready_o      <= 1'b0;
      err_commit_o <= 1'b0;
      err_nest_o   <= 1'b0;
    end else begin
      depth_q      <= depth_n;
      open_q       <= open_n;
      ok_q         <= ok_n;
      pend_q       <= pend_n;
      ready_o      <= ready_n;
      err_commit_o <= cerr_n;
      err_nest_o   <= nerr_n;
    end
  end
endmodule

// File: rtl/ntx_set_tracker.sv
module ntx_set_tracker #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 16,
  parameter int LEVELS = 4,
  localparam int DEPTH_W = $clog2(LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         cmd_op,
  input  logic [DEPTH_W-1:0] cmd_lvl,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               snp_valid,
  input  logic [ADDR_W-1:0]  snp_addr,
  output logic [DEPTH_W-1:0] depth,
  output logic               ready,
  output logic               err_commit,
  output logic               err_nest,
  output logic               ovf,
  output logic               viol_valid,
  output logic [DEPTH_W-1:0] viol_level,
  output logic               pub_valid,
  output logic [LINES-1:0]   pub_mask
);
  localparam int LVL_IW = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  logic              acc_en, clr_en, merge_en, rel_en;
  logic [LVL_IW-1:0] acc_lvl, clr_from, merge_lvl, rel_lvl;
  logic [LEVELS-1:0] snp_hit;

  ntx_ctrl #(.LEVELS(LEVELS)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_lvl(cmd_lvl),
    .acc_valid(acc_valid), .snp_valid(snp_valid), .snp_hit(snp_hit),
    .depth_o(depth), .acc_en(acc_en), .acc_lvl(acc_lvl),
    .clr_en(clr_en), .clr_from(clr_from),
    .merge_en(merge_en), .merge_lvl(merge_lvl),
    .rel_en(rel_en), .rel_lvl(rel_lvl),
    .ready_o(ready), .err_commit_o(err_commit), .err_nest_o(err_nest)
  );

  ntx_tagstore #(.ADDR_W(ADDR_W), .LINES(LINES), .LEVELS(LEVELS)) u_store (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_write),
    .acc_addr(acc_addr), .acc_lvl(acc_lvl), .snp_addr(snp_addr),
    .clr_en(clr_en), .clr_from(clr_from),
    .merge_en(merge_en), .merge_lvl(merge_lvl),
    .rel_en(rel_en), .rel_lvl(rel_lvl),
    .snp_hit(snp_hit), .ovf_o(ovf),
    .pub_valid_o(pub_valid), .pub_mask_o(pub_mask)
  );

  ntx_viol #(.LEVELS(LEVELS)) u_viol (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_hit(snp_hit),
    .viol_valid(viol_valid), .viol_level(viol_level)
  );
endmodule

// File: rtl/ntx_set_tracker_chk.sv
module ntx_set_tracker_chk #(
  parameter int LINES  = 16,
  parameter int LEVELS = 4,
  localparam int DEPTH_W = $clog2(LEVELS + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_valid,
  input logic               snp_valid,
  input logic [DEPTH_W-1:0] depth,
  input logic               err_commit,
  input logic               err_nest,
  input logic               ovf,
  input logic               viol_valid,
  input logic [DEPTH_W-1:0] viol_level,
  input logic               pub_valid,
  input logic [LINES-1:0]   pub_mask
);
  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (rst)
    depth <= DEPTH_W'(LEVELS)); // R2
  AST_NEST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    err_nest |-> $stable(depth)); // R2
  AST_VIOL_LEVEL_OK: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> (viol_level != '0 && viol_level <= DEPTH_W'(LEVELS))); // R4
  AST_VIOL_AFTER_SNOOP: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> $past(snp_valid)); // R4
  AST_OVF_AFTER_ACC: assert property (@(posedge clk) disable iff (rst)
    ovf |-> $past(acc_valid)); // R5
  AST_COMMIT_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    err_commit |-> $stable(depth)); // R7
  AST_PUB_POPS: assert property (@(posedge clk) disable iff (rst)
    pub_valid |-> (depth + 1'b1 == $past(depth))); // R9
  AST_PUB_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !pub_valid |-> pub_mask == '0); // R9
endmodule

bind ntx_set_tracker ntx_set_tracker_chk #(.LINES(LINES), .LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .snp_valid(snp_valid),
  .depth(depth), .err_commit(err_commit), .err_nest(err_nest), .ovf(ovf),
  .viol_valid(viol_valid), .viol_level(viol_level),
  .pub_valid(pub_valid), .pub_mask(pub_mask)
);

// File: tb/tb_ntx_set_tracker.sv
module tb_ntx_set_tracker;
  import ntx_pkg::*;

  typedef struct packed {
    logic [2:0]  d;
    logic        vv;
    logic [2:0]  vl;
    logic        rdy;
    logic        ec;
    logic        en;
    logic        ov;
    logic        pv;
    logic [15:0] pm;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  cmd_lvl = 3'd0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        snp_valid = 1'b0;
  logic [15:0] snp_addr = '0;
  logic [2:0]  depth, viol_level;
  logic        ready, err_commit, err_nest, ovf, viol_valid, pub_valid;
  logic [15:0] pub_mask;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  exp_t  exp_q[$];
  string req_q[$];

  always #5 clk = ~clk;

  ntx_set_tracker dut (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_lvl(cmd_lvl),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .depth(depth), .ready(ready), .err_commit(err_commit), .err_nest(err_nest),
    .ovf(ovf), .viol_valid(viol_valid), .viol_level(viol_level),
    .pub_valid(pub_valid), .pub_mask(pub_mask)
  );

  function automatic exp_t mk(input logic [2:0] d, input logic vv, input logic [2:0] vl,
                              input logic rdy, input logic ec, input logic en,
                              input logic ov, input logic pv, input logic [15:0] pm);
    exp_t x;
    x = '{d: d, vv: vv, vl: vl, rdy: rdy, ec: ec, en: en, ov: ov, pv: pv, pm: pm};
    return x;
  endfunction

  function automatic exp_t dq(input logic [2:0] d);
    return mk(d, 0, 0, 0, 0, 0, 0, 0, 16'h0);
  endfunction

  function automatic exp_t vq(input logic [2:0] d, input logic [2:0] l);
    return mk(d, 1, l, 0, 0, 0, 0, 0, 16'h0);
  endfunction

  // driver: one cycle of stimulus plus the outputs expected after that edge
  task automatic go(input ntx_op_e op, input logic [2:0] lvl,
                    input logic av, input logic aw, input logic [15:0] aa,
                    input logic sv, input logic [15:0] sa,
                    input exp_t x, input string r);
    @(negedge clk);
    cmd_op = op; cmd_lvl = lvl;
    acc_valid = av; acc_write = aw; acc_addr = aa;
    snp_valid = sv; snp_addr = sa;
    exp_q.push_back(x);
    req_q.push_back(r);
  endtask

  task automatic cmd(input ntx_op_e op, input logic [2:0] lvl, input exp_t x, input string r);
    go(op, lvl, 0, 0, 16'h0, 0, 16'h0, x, r);
  endtask

  task automatic acc(input logic w, input logic [15:0] a, input exp_t x, input string r);
    go(OP_NONE, 0, 1, w, a, 0, 16'h0, x, r);
  endtask

  task automatic snp(input logic [15:0] a, input exp_t x, input string r);
    go(OP_NONE, 0, 0, 0, 16'h0, 1, a, x, r);
  endtask

  // monitor: compare the whole output vector after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e, g;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      g = {depth, viol_valid, viol_level, ready, err_commit, err_nest, ovf, pub_valid, pub_mask};
      checks++;
      if (g !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", r, g, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [15:0] A = 16'h0010, B = 16'h0020, C = 16'h0030;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmd(OP_NONE, 0, dq(0), "R1 reset state");
    cmd(OP_BEGIN_C, 0, dq(1), "R2 begin closed");
    acc(0, A, dq(1), "R3 read at level 1");
    cmd(OP_BEGIN_C, 0, dq(2), "R2 begin closed nested");
    acc(1, B, dq(2), "R3 write at level 2");
    snp(A, vq(2, 1), "R4 snoop hits level 1 read");
    cmd(OP_VALIDATE, 0, mk(2, 0, 0, 1, 0, 0, 0, 0, 0), "R6 validate clean child");
    cmd(OP_COMMIT, 0, dq(1), "R8 closed commit folds");
    snp(B, vq(1, 1), "R8 child write now parent level");
    cmd(OP_VALIDATE, 0, dq(1), "R6 validate refused with pending");
    cmd(OP_COMMIT, 0, mk(1, 0, 0, 0, 1, 0, 0, 0, 0), "R7 commit without validate");
    cmd(OP_ABORT, 2, dq(1), "R10 out of range abort ignored");
    cmd(OP_ABORT, 1, dq(0), "R10 abort outermost");
    snp(A, dq(0), "R10 aborted sets released");
    acc(0, B, dq(0), "R3 access at depth 0");
    snp(B, dq(0), "R3 depth 0 access untracked");
    // same-cycle validate and hitting snoop
    cmd(OP_BEGIN_C, 0, dq(1), "R2 begin");
    acc(1, C, dq(1), "R3 write C");
    go(OP_VALIDATE, 0, 0, 0, 16'h0, 1, C, vq(1, 1), "R6 snoop same cycle as validate");
    cmd(OP_ABORT, 1, dq(0), "R10 abort");
    // violation between validate and commit
    cmd(OP_BEGIN_C, 0, dq(1), "R2 begin");
    acc(0, A, dq(1), "R3 read A");
    cmd(OP_VALIDATE, 0, mk(1, 0, 0, 1, 0, 0, 0, 0, 0), "R6 validate ok");
    snp(A, vq(1, 1), "R4 snoop after validate");
    cmd(OP_COMMIT, 0, mk(1, 0, 0, 0, 1, 0, 0, 0, 0), "R7 violation revokes validate");
    cmd(OP_ABORT, 1, dq(0), "R10 abort");
    // shallowest level reported
    cmd(OP_BEGIN_C, 0, dq(1), "R2 begin");
    acc(0, A, dq(1), "R3 read A l1");
    cmd(OP_BEGIN_O, 0, dq(2), "R2 begin open");
    acc(0, A, dq(2), "R3 read A l2");
    cmd(OP_BEGIN_C, 0, dq(3), "R2 begin");
    acc(1, A, dq(3), "R3 write A l3");
    snp(A, vq(3, 1), "R4 shallowest of three levels");
    cmd(OP_ABORT, 2, dq(1), "R10 abort level 2 and deeper");
    snp(A, vq(1, 1), "R10 level 1 bits kept");
    cmd(OP_ABORT, 1, dq(0), "R10 abort");
    // nesting limit and open publish
    cmd(OP_BEGIN_C, 0, dq(1), "R2 begin");
    cmd(OP_BEGIN_O, 0, dq(2), "R2 begin");
    cmd(OP_BEGIN_C, 0, dq(3), "R2 begin");
    cmd(OP_BEGIN_O, 0, dq(4), "R2 begin to max");
    cmd(OP_BEGIN_C, 0, mk(4, 0, 0, 0, 0, 1, 0, 0, 0), "R2 begin past max rejected");
    acc(1, A, dq(4), "R3 write A line0");
    acc(1, B, dq(4), "R3 write B line1");
    acc(0, C, dq(4), "R3 read C line2");
    cmd(OP_VALIDATE, 0, mk(4, 0, 0, 1, 0, 0, 0, 0, 0), "R6 validate");
    cmd(OP_COMMIT, 0, mk(3, 0, 0, 0, 0, 0, 0, 1, 16'h0003), "R9 open commit publishes");
    snp(A, dq(3), "R9 open child sets released");
    acc(0, C, dq(3), "R3 read C at level 3");
    cmd(OP_ABORT, 2, dq(1), "R10 abort level 2");
    snp(C, dq(1), "R10 level 3 cleared");
    // line store exhaustion
    for (int i = 0; i < 16; i++) acc(0, 16'h0100 + 16'(i), dq(1), "R5 fill line");
    acc(0, 16'h0200, mk(1, 0, 0, 0, 0, 0, 1, 0, 0), "R5 overflow flagged");
    snp(16'h0200, dq(1), "R5 overflow left no state");
    snp(16'h010F, vq(1, 1), "R5 held lines intact");
    cmd(OP_ABORT, 1, dq(0), "R10 abort");
    // outermost publish
    cmd(OP_BEGIN_C, 0, dq(1), "R2 begin");
    acc(1, B, dq(1), "R3 write B");
    acc(1, C, dq(1), "R3 write C");
    cmd(OP_VALIDATE, 0, mk(1, 0, 0, 1, 0, 0, 0, 0, 0), "R6 validate");
    cmd(OP_COMMIT, 0, mk(0, 0, 0, 0, 0, 0, 0, 1, 16'h0003), "R9 outermost commit publishes");
    snp(B, dq(0), "R9 outermost sets released");
    @(negedge clk);
    cmd_op = 3'd0; acc_valid = 1'b0; snp_valid = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule